// File: doc/BRIEF.md
# GPIO Port Output Register Bank

This block holds the pin-control registers for several groups of general-purpose I/O pins, each group up to 32 pins wide. Software reaches it over a simple synchronous register bus. Each group keeps a direction word, an output value word and a pull-enable word. A write-one-to-clear alias of the output word lets software drive chosen pins low in a single write, with no read-modify-write.

The pad control outputs follow from the three words for each pin. A pin set to output drives its output bit. A pin set to input with its pull enabled takes its pull direction from the same output bit: a 1 selects a pull-up and a 0 selects a pull-down. A write-protection input blocks writes to every register while it is high.

Top module: `gpio_port_bank`

## Requirements
- R1: After synchronous reset, every direction, output and pull-enable bit is 0, every pad output is 0, and `bus_rdata` is 0.
- R2: Group g occupies byte addresses g*0x80 to g*0x80+0x7F. Inside a group the direction word sits at offset 0x00, the output word at 0x10, the clear alias at 0x14 and the pull-enable word at 0x40. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R3: A write to the direction, output or pull-enable word stores all 32 bits of `bus_wdata`.
- R4: A write to the clear alias clears each output bit whose `bus_wdata` bit is 1 and leaves each output bit whose `bus_wdata` bit is 0 unchanged. A write of all zeros has no effect on any pad.
- R5: A read of the clear alias returns the current output word and changes no state.
- R6: For each pin, `pad_oe` equals the direction bit, where 1 means output. `pad_level` equals the output bit while the pin is an output and is 0 while it is an input.
- R7: For each pin, `pad_pull_en` is 1 only when the direction bit is 0 and the pull-enable bit is 1. `pad_pull_up` is 1 only when `pad_pull_en` is 1 and the output bit is 1. With the pull enabled, an output bit of 0 therefore means pull-down.
- R8: While `bus_wprot` is 1, a bus write changes no register and no pad output.
- R9: A read at an unmapped offset, at an address that is not word-aligned, or in a group at or above `N_GROUPS` returns 0. A write to such an address changes nothing.
- R10: A write shows on the pad outputs right after the clock edge that takes it, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wprot | input | 1 | Write protection; blocks all writes while high |
| bus_rdata | output | 32 | Registered read data |
| pad_oe | output | N_GROUPS*PINS (96) | Output enable for each pin, pin g*PINS+i |
| pad_level | output | N_GROUPS*PINS (96) | Drive level for each pin |
| pad_pull_en | output | N_GROUPS*PINS (96) | Pull resistor enabled |
| pad_pull_up | output | N_GROUPS*PINS (96) | Pull direction: 1 = up, 0 = down |

## Verification
The assertions check on every cycle that a clear write zeroes exactly the bits written as 1 and keeps the rest (R4). They also check that a protected write leaves all state frozen (R8), that no pin has output drive and a pull at once (R6, R7), that a pull-up never appears without an enabled pull (R7), and that an unmapped read returns zero (R9). The address map, full-word stores, the read-back of the clear alias, reset values and same-edge pad updates (R1, R2, R3, R5, R10) only show up in the bench's scenarios. Those scenarios compare every read and every pad vector with a model kept alongside the stimulus.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Byte offsets inside one group window
    localparam logic [6:0] OFS_DIR  = 7'h00;
    localparam logic [6:0] OFS_OUT  = 7'h10;
    localparam logic [6:0] OFS_CLR  = 7'h14;
    localparam logic [6:0] OFS_PEN  = 7'h40;
    localparam int         WIN_BITS = 7;      // 0x80 bytes per group
    localparam int         DATA_W   = 32;

    typedef enum logic [2:0] {
        RK_DIR,
        RK_OUT,
        RK_CLR,
        RK_PEN,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic oe;
        logic level;
        logic pull_en;
        logic pull_up;
    } pad_ctl_t;

    // Pad control for one pin from its three register bits
    function automatic pad_ctl_t pad_ctl_f(input logic dir, input logic outv, input logic pen);
        pad_ctl_t c;
        c.oe      = dir;
        c.level   = dir & outv;
        c.pull_en = ~dir & pen;
        c.pull_up = ~dir & pen & outv;
        return c;
    endfunction

    function automatic reg_kind_e ofs_kind_f(input logic [6:0] ofs);
        reg_kind_e k;
        case (ofs)
            OFS_DIR: k = RK_DIR;
            OFS_OUT: k = RK_OUT;
            OFS_CLR: k = RK_CLR;
            OFS_PEN: k = RK_PEN;
            default: k = RK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int N_GROUPS = 3,
    parameter int ADDR_W   = 10,
    localparam int GRP_W   = ADDR_W - WIN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [GRP_W-1:0]  grp,
    output reg_kind_e         kind
);
    logic grp_ok;
    logic aligned;

    assign grp     = addr[ADDR_W-1:WIN_BITS];
    assign grp_ok  = (int'(grp) < N_GROUPS);
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        if (grp_ok && aligned) kind = ofs_kind_f(addr[WIN_BITS-1:0]);
        else                   kind = RK_NONE;
    end
endmodule

// File: rtl/gpio_group.sv
module gpio_group
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic              wprot,
    input  reg_kind_e         kind,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   pen_q,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_level,
    output logic [PINS-1:0]   pad_pull_en,
    output logic [PINS-1:0]   pad_pull_up
);
    logic wr_ok;
    assign wr_ok = wr_sel & ~wprot;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
            pen_q <= '0;
        end else if (wr_ok) begin
            case (kind)
                RK_DIR:  dir_q <= wdata;
                RK_OUT:  out_q <= wdata;
                RK_CLR:  out_q <= out_q & ~wdata;
                RK_PEN:  pen_q <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl            = pad_ctl_f(dir_q[i], out_q[i], pen_q[i]);
        assign pad_oe[i]      = ctl.oe;
        assign pad_level[i]   = ctl.level;
        assign pad_pull_en[i] = ctl.pull_en;
        assign pad_pull_up[i] = ctl.pull_up;
    end

    // R4
    clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wprot && kind == RK_CLR) |=> ((out_q & $past(wdata)) == '0));
    // R4
    clr_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && !wprot && kind == RK_CLR) |=>
        ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
    // R8
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && wprot) |=> ($stable(out_q) && $stable(dir_q) && $stable(pen_q)));
    // R7
    pull_up_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_pull_up & ~pad_pull_en) == '0));
    // R6
    drive_pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_pull_en) == '0));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_port_pkg::*;
#(
    parameter int N_GROUPS = 3,
    parameter int PINS     = 32,
    parameter int ADDR_W   = 10,
    localparam int GRP_W   = ADDR_W - WIN_BITS,
    localparam int NPIN    = N_GROUPS * PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wprot,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_level,
    output logic [NPIN-1:0]   pad_pull_en,
    output logic [NPIN-1:0]   pad_pull_up
);
    logic [GRP_W-1:0] grp;
    reg_kind_e        kind;

    gpio_addr_dec #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .grp  (grp),
        .kind (kind)
    );

    logic [PINS-1:0] dir_w [N_GROUPS];
    logic [PINS-1:0] out_w [N_GROUPS];
    logic [PINS-1:0] pen_w [N_GROUPS];

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic wr_sel;
        assign wr_sel = bus_sel & bus_we & (grp == GRP_W'(g)) & (kind != RK_NONE);

        gpio_group #(.PINS(PINS)) u_grp (
            .clk         (clk),
            .rst         (rst),
            .wr_sel      (wr_sel),
            .wprot       (bus_wprot),
            .kind        (kind),
            .wdata       (bus_wdata[PINS-1:0]),
            .dir_q       (dir_w[g]),
            .out_q       (out_w[g]),
            .pen_q       (pen_w[g]),
            .pad_oe      (pad_oe[g*PINS +: PINS]),
            .pad_level   (pad_level[g*PINS +: PINS]),
            .pad_pull_en (pad_pull_en[g*PINS +: PINS]),
            .pad_pull_up (pad_pull_up[g*PINS +: PINS])
        );
    end

    // Read word selection; the clear alias reads back the output word
    logic [DATA_W-1:0] rd_word;
    always_comb begin
        rd_word = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (grp == GRP_W'(g)) begin
                case (kind)
                    RK_DIR:         rd_word = DATA_W'(dir_w[g]);
                    RK_OUT, RK_CLR: rd_word = DATA_W'(out_w[g]);
                    RK_PEN:         rd_word = DATA_W'(pen_w[g]);
                    default:        rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     bus_rdata <= '0;
        else if (bus_sel && !bus_we) bus_rdata <= rd_word;
    end

    // R9
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && kind == RK_NONE) |=> (bus_rdata == '0));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;
    localparam int NG = 3;
    localparam int PN = 32;
    localparam int AW = 10;
    localparam int NP = NG * PN;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_sel, bus_we, bus_wprot;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [NP-1:0] pad_oe, pad_level, pad_pull_en, pad_pull_up;

    always #2.5 clk = ~clk;

    gpio_port_bank #(.N_GROUPS(NG), .PINS(PN), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wprot(bus_wprot),
        .bus_rdata(bus_rdata), .pad_oe(pad_oe), .pad_level(pad_level),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_dir [NG];
    logic [31:0] m_out [NG];
    logic [31:0] m_pen [NG];

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected read value from the model; 0 for unmapped
    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int g;
        g = int'(a[AW-1:7]);
        if (g >= NG || a[1:0] != 2'b00) return 32'h0;
        case (a[6:0])
            7'h00: return m_dir[g];
            7'h10: return m_out[g];
            7'h14: return m_out[g];
            7'h40: return m_pen[g];
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic p);
        int g;
        g = int'(a[AW-1:7]);
        if (p || g >= NG || a[1:0] != 2'b00) return;
        case (a[6:0])
            7'h00: m_dir[g] = d;
            7'h10: m_out[g] = d;
            7'h14: m_out[g] = m_out[g] & ~d;
            7'h40: m_pen[g] = d;
            default: ;
        endcase
    endfunction

    task automatic check_pads(input string req);
        logic [NP-1:0] eo, el, ep, eu;
        for (int g = 0; g < NG; g++) begin
            eo[g*PN +: PN] = m_dir[g];
            el[g*PN +: PN] = m_dir[g] & m_out[g];
            ep[g*PN +: PN] = ~m_dir[g] & m_pen[g];
            eu[g*PN +: PN] = ~m_dir[g] & m_pen[g] & m_out[g];
        end
        chk({req, " oe"}, pad_oe, eo);
        chk({req, " level"}, pad_level, el);
        chk({req, " pull_en"}, pad_pull_en, ep);
        chk({req, " pull_up"}, pad_pull_up, eu);
    endtask

    // Inputs change at negedge; results sampled at the following negedge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic p, input string req);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wprot = p;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wprot = 1'b0;
        model_write(a, d, p);
        check_pads(req);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk(req, NP'(bus_rdata), NP'(exp_read(a)));
    endtask

    function automatic logic [AW-1:0] mk_addr(input int g, input int k);
        logic [6:0] o;
        case (k)
            0: o = 7'h00; 1: o = 7'h10; 2: o = 7'h14; 3: o = 7'h40;
            4: o = 7'h20; default: o = 7'h15;
        endcase
        return {3'(g), o};
    endfunction

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        for (int g = 0; g < NG; g++) begin m_dir[g] = 0; m_out[g] = 0; m_pen[g] = 0; end
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_wprot = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_pads("R1");
        chk("R1 rdata", NP'(bus_rdata), '0);
        for (int g = 0; g < NG; g++)
            for (int k = 0; k < 4; k++) rd(mk_addr(g, k), "R1 reg");

        // R3 R2 full-word store at group 1 (base 0x80)
        wr(10'h080, 32'hF0F0_00FF, 1'b0, "R3 R10 dir");
        wr(10'h090, 32'hA5A5_3C3C, 1'b0, "R3 R6 out");
        wr(10'h0C0, 32'h0FF0_FF00, 1'b0, "R3 R7 pen");
        rd(10'h080, "R2 dir g1");
        rd(10'h0C0, "R2 pen g1");
        // R5 clear alias read returns output word, no side effect
        rd(10'h094, "R5 clr read");
        rd(10'h090, "R5 out after clr read");
        check_pads("R5");
        // R4 clear with zero word: no change
        wr(10'h094, 32'h0, 1'b0, "R4 zero clr");
        // R4 partial clear
        wr(10'h094, 32'h0F0F_0F0F, 1'b0, "R4 clr");
        rd(10'h090, "R4 out after clr");
        // R7 pull-down after clearing pulled input bits
        wr(10'h094, 32'hFFFF_FFFF, 1'b0, "R7 all clr");
        // R8 protected writes
        wr(10'h010, 32'hFFFF_FFFF, 1'b1, "R8 out");
        wr(10'h000, 32'hFFFF_FFFF, 1'b1, "R8 dir");
        wr(10'h094, 32'hFFFF_FFFF, 1'b1, "R8 clr");
        rd(10'h010, "R8 readback");
        // R9 unmapped group 3, misaligned, hole offset
        wr(10'h190, 32'hFFFF_FFFF, 1'b0, "R9 grp3 wr");
        rd(10'h190, "R9 grp3 rd");
        wr(10'h011, 32'hFFFF_FFFF, 1'b0, "R9 misaligned wr");
        rd(10'h020, "R9 hole rd");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int g, k;
            logic [AW-1:0] a;
            g = int'($urandom_range(0, 4));
            k = int'($urandom_range(0, 5));
            a = mk_addr(g, k);
            if ($urandom_range(0, 1) == 1)
                wr(a, $urandom(), ($urandom_range(0, 7) == 0), "R3 R4 R8 R9 rand wr");
            else
                rd(a, "R2 R5 R9 rand rd");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule